// File: doc/BRIEF.md
# Track Event Frame Generator

This block plays back one fixed trigger-track event as a framed sequence of 24-bit words for a serial-link transmitter working in 20-bit mode. Each word carries an 8-bit link control code in its upper bits and a 16-bit data field below it. While nothing is happening, the block sends filler words. A single-cycle trigger pulse starts one frame, which has three parts in this order: a typed header word, eight stored payload words, and a trailer whose data is a longitudinal XOR parity built while the frame goes out. After the trailer the block goes back to filler.

A busy flag is high for the whole frame. A trigger that arrives while busy is high has no effect. The 16 data bits are mirrored before they leave the block, and a parameter can turn this off. The control code bits are never mirrored. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `trkframe_gen`

## Requirements
- R1: With no frame in progress, `word_o` is 0xF00000 (control type F, sub-code 0, data zero) and `busy_o` is low.
- R2: A trigger sampled high on a rising edge while `busy_o` is low makes `busy_o` high in the next cycle. In that cycle `word_o` carries control code 0xB5 in bits 23:16 and data 0x0301 in bits 15:0, with the data mirrored as stated in R6.
- R3: For the eight cycles after the header, the control code is 0xB0. The data fields are 0x1110, 0x01A2, 0xFFFF, 0x0000, 0x0000, 0x0114, 0x3C02 and 0xA201, in that order, with the data mirrored as stated in R6.
- R4: The cycle after the last payload word carries control code 0xBA. Its data is the XOR of the header data and the eight payload data fields, which is 0x735B before mirroring.
- R5: `busy_o` stays high for exactly ten cycles, from the header through the trailer. In the cycle after the trailer, `busy_o` is low and the filler word of R1 is on the output.
- R6: With `REVERSE_BITS`=1, output bit i (for i from 0 to 15) carries bit 15-i of the data field, and bits 23:16 are passed unchanged. With `REVERSE_BITS`=0, the data field is sent as it is.
- R7: A trigger sampled while `busy_o` is high is ignored. The current frame keeps its words and its length, and no frame follows it.
- R8: A low `rst_n` forces the R1 output at once and abandons any frame. After `rst_n` rises, no trigger is taken on the first `SYNC_STAGES` rising edges. A trigger held high is accepted on edge `SYNC_STAGES`+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_i | input | 1 | Single-cycle frame start request |
| word_o | output | 24 | Link word: control code in 23:16, data in 15:0 |
| busy_o | output | 1 | High while a frame word is on the output |

## Verification
Each frame word appears in a fixed cycle: the header shows in the cycle after the edge that samples the trigger, and payload word k shows k cycles after that. The trailer comes ten cycles after the trigger edge and the first filler word eleven cycles after it. The bench keeps its own frame position counter, which it advances on every rising edge. It compares both a mirrored and an unmirrored instance on the falling edge that follows, so each compare sees the word due for that exact cycle. After a reset release, the bench counts the edges itself. It expects busy to stay low through the `SYNC_STAGES` synchroniser edges and to rise only after the next one.

// File: rtl/trkframe_pkg.sv
package trkframe_pkg;
  localparam int CODE_W = 8;
  localparam int DATA_W = 16;
  localparam int WORD_W = CODE_W + DATA_W;
  localparam int N_BODY = 8;
  localparam int IDX_W  = $clog2(N_BODY);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_BODY = 2'd2,
    ST_TAIL = 2'd3
  } trk_state_e;

  localparam logic [CODE_W-1:0] CODE_FILL = 8'hF0;
  localparam logic [CODE_W-1:0] CODE_HEAD = 8'hB5;
  localparam logic [CODE_W-1:0] CODE_BODY = 8'hB0;
  localparam logic [CODE_W-1:0] CODE_TAIL = 8'hBA;
  localparam logic [DATA_W-1:0] HEAD_DATA = 16'h0301;

  // stored event payload, fixed order
  function automatic logic [DATA_W-1:0] body_word(input logic [IDX_W-1:0] sel);
    logic [DATA_W-1:0] v;
    case (sel)
      3'd0:    v = 16'h1110;
      3'd1:    v = 16'h01A2;
      3'd2:    v = 16'hFFFF;
      3'd3:    v = 16'h0000;
      3'd4:    v = 16'h0000;
      3'd5:    v = 16'h0114;
      3'd6:    v = 16'h3C02;
      default: v = 16'hA201;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/trkframe_rstsync.sv
module trkframe_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/trkframe_seq.sv
module trkframe_seq
  import trkframe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  output trk_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BODY - 1);

  trk_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             adv_en;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_IDLE: if (trig_i) st_d = ST_HEAD;
      ST_HEAD: begin
        st_d  = ST_BODY;
        idx_d = '0;
      end
      ST_BODY: begin
        if (idx_q == LAST_IDX) st_d = ST_TAIL;
        else                   idx_d = idx_q + IDX_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign adv_en = (st_q != ST_IDLE) | trig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (adv_en) begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;
  assign busy_o  = (st_q != ST_IDLE);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && trig_i) |=> (busy_o && st_q == ST_HEAD));

  assert_rise_needs_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(trig_i));

  assert_tail_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAIL) |=> !busy_o);
endmodule

// File: rtl/trkframe_fmt.sv
module trkframe_fmt
  import trkframe_pkg::*;
#(
  parameter bit REVERSE_BITS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trk_state_e        state_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  logic [DATA_W-1:0] body_val;
  logic [DATA_W-1:0] par_q, par_d;
  logic              par_en;
  logic [CODE_W-1:0] code_raw;
  logic [DATA_W-1:0] data_raw, data_tx;

  assign body_val = body_word(idx_i);

  // parity: header loads (clears old frame), payload accumulates
  assign par_en = (state_i == ST_HEAD) || (state_i == ST_BODY);
  assign par_d  = (state_i == ST_HEAD) ? HEAD_DATA : (par_q ^ body_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      par_q <= '0;
    else if (par_en) par_q <= par_d;
  end

  always_comb begin
    case (state_i)
      ST_HEAD: begin code_raw = CODE_HEAD; data_raw = HEAD_DATA; end
      ST_BODY: begin code_raw = CODE_BODY; data_raw = body_val;  end
      ST_TAIL: begin code_raw = CODE_TAIL; data_raw = par_q;     end
      default: begin code_raw = CODE_FILL; data_raw = '0;        end
    endcase
  end

  generate
    if (REVERSE_BITS) begin : g_rev
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        assign data_tx[gi] = data_raw[DATA_W-1-gi];
      end
    end else begin : g_pass
      assign data_tx = data_raw;
    end
  endgenerate

  assign word_o = {code_raw, data_tx};

  assert_trailer_then_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_o[WORD_W-1:DATA_W] == CODE_TAIL) |=> (word_o[WORD_W-1:DATA_W] == CODE_FILL));

  assert_head_then_body_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_o[WORD_W-1:DATA_W] == CODE_HEAD) |=> (word_o[WORD_W-1:DATA_W] == CODE_BODY));
endmodule

// File: rtl/trkframe_gen.sv
module trkframe_gen
  import trkframe_pkg::*;
#(
  parameter bit REVERSE_BITS = 1'b1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_i,
  output logic [23:0] word_o,
  output logic        busy_o
);
  logic             srst_n;
  trk_state_e       state;
  logic [IDX_W-1:0] idx;

  trkframe_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  trkframe_seq u_seq (
    .clk     (clk),
    .rst_n   (srst_n),
    .trig_i  (trig_i),
    .state_o (state),
    .idx_o   (idx),
    .busy_o  (busy_o)
  );

  trkframe_fmt #(.REVERSE_BITS(REVERSE_BITS)) u_fmt (
    .clk     (clk),
    .rst_n   (srst_n),
    .state_i (state),
    .idx_i   (idx),
    .word_o  (word_o)
  );

  assert_idle_fill_R1: assert property (@(posedge clk) disable iff (!srst_n)
    !busy_o |-> (word_o == 24'hF00000));
endmodule

// File: tb/trkframe_gen_bench.sv
`timescale 1ns/1ps
module trkframe_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig;
  logic [23:0] word_r, word_p;
  logic        busy_r, busy_p;
  int          checks = 0;
  int          fails  = 0;
  int          pos    = 0;
  bit          drop_seen = 1'b0;

  always #2.5 clk = ~clk;

  trkframe_gen #(.REVERSE_BITS(1'b1), .SYNC_STAGES(2)) u_trkframe_gen (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .word_o(word_r), .busy_o(busy_r));

  trkframe_gen #(.REVERSE_BITS(1'b0), .SYNC_STAGES(2)) u_trkframe_gen_plain (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .word_o(word_p), .busy_o(busy_p));

  function automatic logic [15:0] body_ref(int k);
    case (k)
      0: return 16'h1110;  1: return 16'h01A2;
      2: return 16'hFFFF;  3: return 16'h0000;
      4: return 16'h0000;  5: return 16'h0114;
      6: return 16'h3C02;  default: return 16'hA201;
    endcase
  endfunction

  function automatic logic [15:0] parity_ref();
    logic [15:0] p = 16'h0301;
    for (int k = 0; k < 8; k++) p ^= body_ref(k);
    return p;
  endfunction

  function automatic logic [15:0] rev16(logic [15:0] d);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) r[b] = d[15-b];
    return r;
  endfunction

  function automatic logic [23:0] exp_word(int p, bit rev);
    logic [7:0]  c;
    logic [15:0] d;
    if (p == 0)       begin c = 8'hF0; d = 16'h0000; end
    else if (p == 1)  begin c = 8'hB5; d = 16'h0301; end
    else if (p <= 9)  begin c = 8'hB0; d = body_ref(p - 2); end
    else              begin c = 8'hBA; d = parity_ref(); end
    if (rev) d = rev16(d);
    return {c, d};
  endfunction

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (pos %0d)", tag, act, exp, pos);
    end
  endtask

  function automatic string pos_tag();
    if (drop_seen && pos != 0) return "R7";
    if (pos == 0)  return "R1";
    if (pos == 1)  return "R2";
    if (pos <= 9)  return "R3";
    return "R4";
  endfunction

  // called at a falling edge: check current cycle, drive trigger, advance model
  task automatic step(bit t);
    chk(pos_tag(), word_r, exp_word(pos, 1'b1));
    chk("R6", word_p, exp_word(pos, 1'b0));
    chk("R5", {23'd0, busy_r}, {23'd0, pos != 0});
    chk("R6", {23'd0, busy_p}, {23'd0, pos != 0});
    if (pos == 10) chk("R4", {8'h00, word_p[15:0]}, 24'h00735B);
    trig = t;
    @(posedge clk);
    if (pos == 0) begin
      if (t) begin pos = 1; drop_seen = 1'b0; end
    end else begin
      if (t) drop_seen = 1'b1;
      pos = (pos == 10) ? 0 : pos + 1;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    trig  = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", word_r, 24'hF00000);
    chk("R8", {23'd0, busy_r}, 24'd0);

    // R8: release, trigger held high, accepted on third edge
    rst_n = 1'b1;
    trig  = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8", {23'd0, busy_r}, 24'd0);
    @(posedge clk); @(negedge clk);
    chk("R8", {23'd0, busy_r}, 24'd0);
    @(posedge clk); @(negedge clk);
    chk("R8", {23'd0, busy_r}, 24'd1);
    chk("R2", word_r, exp_word(1, 1'b1));
    pos = 1;
    drop_seen = 1'b0;
    repeat (12) step(1'b0);

    // R7: triggers inside a frame, including in the trailer cycle
    step(1'b1);
    repeat (3) step(1'b0);
    repeat (3) step(1'b1);
    repeat (3) step(1'b0);
    step(1'b1);
    step(1'b1);
    repeat (12) step(1'b0);

    // back-to-back requests held high
    repeat (30) step(1'b1);
    repeat (12) step(1'b0);

    // constrained random stream
    for (int n = 0; n < 3000; n++) step($urandom_range(0, 3) == 0);
    repeat (12) step(1'b0);

    // R8: asynchronous reset in the middle of a frame
    step(1'b1);
    repeat (4) step(1'b0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R8", word_r, 24'hF00000);
    chk("R8", word_p, 24'hF00000);
    chk("R8", {23'd0, busy_r}, 24'd0);
    @(negedge clk);
    rst_n = 1'b1;
    pos = 0;
    drop_seen = 1'b0;
    repeat (3) step(1'b0);
    step(1'b1);
    repeat (12) step(1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule